// File: doc/BRIEF.md
# Address-Decoded Peripheral Data Bus

This block sits between one processor data port and two targets that share it: a word-organised RAM of 8 KB and a write-only serial transmitter mapped at a single address. Each access address is decoded once, when the request is accepted. The strobe, write data and byte enables then go to the selected target. That target's read data and completion signal come back on the shared port. Addresses that map to neither target complete at once with an error flag and touch nothing.

The transmitter is a small shifter that sends frames of 8 data bits and 1 stop bit, with no parity and no flow control. The bit period is derived from the clock and baud parameters (100 MHz and 9600 baud give 10417 cycles per bit). A read of the transmitter address returns its busy state. A write while a frame is in flight holds the bus until the line is free.

A requester raises `req_i` with address, write flag, data and byte enables for one cycle. It then waits for `ready_o`, and issues no new request until it has seen `ready_o`.

Top module: `dbus_decoder`

## Requirements
- R1: Addresses 0x00000000 to 0x00001FFF select the RAM (word index from address bits 12:2). On a write, byte lane k (data bits 8k+7:8k) is written only when `be_i[k]` is 1. A later read returns the stored word.
- R2: For RAM and invalid accesses, `ready_o` is high in the cycle after the accepting edge, for exactly one cycle.
- R3: A write to 0x00010000 sends `wdata_i[7:0]` as a frame: a low start bit, the 8 data bits least significant first, then a high stop bit. Each bit lasts CLKS_PER_BIT cycles, and the line idles high.
- R4: A read from 0x00010000 returns the transmitter busy state, sampled at acceptance, in bit 0, with bits 31:1 zero.
- R5: A write to 0x00010000 while a frame is in flight keeps `ready_o` low until that frame ends. The new byte is then sent as the next frame.
- R6: Any other address completes with `err_o` high for the one ready cycle and `rdata_o` zero. It changes neither the RAM nor the serial line.
- R7: Read data is chosen by the target latched at acceptance. Later changes of `addr_i` and `we_i` do not alter it.
- R8: After reset, `ready_o` and `err_o` are low and `tx_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte enables for writes |
| rdata_o | output | 32 | Read data, valid with ready_o |
| ready_o | output | 1 | Access complete |
| err_o | output | 1 | Access hit no target |
| tx_o | output | 1 | Serial output line |

## Verification
Some rules are checked by assertions in every cycle. Ready is a one-cycle pulse. An error completion carries zero data. A status read never sets bits above bit 0. A start request always starts a frame whose first bit is low, and every frame ends on a high line. Other behaviour can only be shown by scenarios. These cover byte-lane merging in RAM, and aliasing of an out-of-range address onto RAM word zero. They also cover the exact serial bit order, and the length of the stall when a second byte arrives during a frame.

// File: rtl/dbus_pkg.sv
package dbus_pkg;
  typedef enum logic [1:0] {
    TGT_RAM  = 2'd0,
    TGT_UART = 2'd1,
    TGT_NONE = 2'd2
  } tgt_e;
endpackage

// File: rtl/dbus_decode.sv
module dbus_decode
  import dbus_pkg::*;
#(
  parameter int          RAM_BYTES = 8192,
  parameter logic [31:0] UART_ADDR = 32'h0001_0000
) (
  input  logic [31:0] addr_i,
  output tgt_e        tgt_o
);
  localparam logic [31:0] RAM_LAST = 32'(RAM_BYTES - 1);

  always_comb begin
    if (addr_i <= RAM_LAST)        tgt_o = TGT_RAM;
    else if (addr_i == UART_ADDR)  tgt_o = TGT_UART;
    else                           tgt_o = TGT_NONE;
  end
endmodule

// File: rtl/dbus_ram.sv
module dbus_ram #(
  parameter int DEPTH = 2048,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int NB   = DW / 8
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [NB-1:0] be_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) begin
        for (int b = 0; b < NB; b++)
          if (be_i[b]) mem_q[addr_i][8*b +: 8] <= wdata_i[8*b +: 8];
      end else begin
        rd_q <= mem_q[addr_i];
      end
    end
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/dbus_uart_tx.sv
module dbus_uart_tx #(
  parameter int CLKS_PER_BIT = 10417,
  localparam int CW = $clog2(CLKS_PER_BIT + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] data_i,
  output logic       busy_o,
  output logic       tx_o
);
  localparam logic [CW-1:0] CNT_LAST = CW'(CLKS_PER_BIT - 1);

  logic [CW-1:0] cnt_q;
  logic [3:0]    idx_q;
  logic [9:0]    sh_q;
  logic          active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      idx_q    <= '0;
      sh_q     <= '1;
      active_q <= 1'b0;
    end else if (start_i && !active_q) begin
      sh_q     <= {1'b1, data_i, 1'b0};
      cnt_q    <= '0;
      idx_q    <= '0;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (cnt_q == CNT_LAST) begin
        cnt_q <= '0;
        sh_q  <= {1'b1, sh_q[9:1]};
        if (idx_q == 4'd9) active_q <= 1'b0;
        else               idx_q    <= idx_q + 4'd1;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign busy_o = active_q;
  assign tx_o   = active_q ? sh_q[0] : 1'b1;

  a_r3_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !tx_o));
  a_r3_stop_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(tx_o));
endmodule

// File: rtl/dbus_decoder.sv
module dbus_decoder
  import dbus_pkg::*;
#(
  parameter int          RAM_BYTES = 8192,
  parameter logic [31:0] UART_ADDR = 32'h0001_0000,
  parameter int          CLK_HZ    = 100_000_000,
  parameter int          BAUD      = 9600
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [31:0] addr_i,
  input  logic [31:0] wdata_i,
  input  logic [3:0]  be_i,
  output logic [31:0] rdata_o,
  output logic        ready_o,
  output logic        err_o,
  output logic        tx_o
);
  localparam int CLKS_PER_BIT = (CLK_HZ + BAUD / 2) / BAUD;
  localparam int RAM_WORDS    = RAM_BYTES / 4;
  localparam int RAM_AW       = $clog2(RAM_WORDS);

  tgt_e        tgt_d, tgt_q;
  logic        pend_q, we_q, stat_q;
  logic [7:0]  byte_q;
  logic [31:0] ram_rdata;
  logic        accept, ram_en, uart_wr, tx_busy, tx_start;

  dbus_decode #(.RAM_BYTES(RAM_BYTES), .UART_ADDR(UART_ADDR)) u_dec (
    .addr_i (addr_i),
    .tgt_o  (tgt_d)
  );

  assign accept = req_i && !pend_q;
  assign ram_en = accept && (tgt_d == TGT_RAM);

  dbus_ram #(.DEPTH(RAM_WORDS), .DW(32)) u_ram (
    .clk_i   (clk_i),
    .en_i    (ram_en),
    .we_i    (we_i),
    .be_i    (be_i),
    .addr_i  (addr_i[RAM_AW+1:2]),
    .wdata_i (wdata_i),
    .rdata_o (ram_rdata)
  );

  // pending transmitter write waits for the line to free up
  assign uart_wr  = pend_q && (tgt_q == TGT_UART) && we_q;
  assign tx_start = uart_wr && !tx_busy;
  assign ready_o  = pend_q && !(uart_wr && tx_busy);
  assign err_o    = ready_o && (tgt_q == TGT_NONE);

  dbus_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tx_start),
    .data_i  (byte_q),
    .busy_o  (tx_busy),
    .tx_o    (tx_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      tgt_q  <= TGT_NONE;
      we_q   <= 1'b0;
      stat_q <= 1'b0;
      byte_q <= '0;
    end else if (accept) begin
      pend_q <= 1'b1;
      tgt_q  <= tgt_d;
      we_q   <= we_i;
      stat_q <= tx_busy;
      byte_q <= wdata_i[7:0];
    end else if (ready_o) begin
      pend_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (ready_o && !we_q) begin
      unique case (tgt_q)
        TGT_RAM:  rdata_o = ram_rdata;
        TGT_UART: rdata_o = {31'b0, stat_q};
        default:  rdata_o = '0;
      endcase
    end
  end

  a_r2_ready_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  a_r6_err_zero_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (ready_o && rdata_o == '0));
  a_r4_status_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && tgt_q == TGT_UART && !we_q) |-> (rdata_o[31:1] == '0));
  a_r5_start_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start |=> tx_busy);
endmodule

// File: tb/dbus_decoder_test.sv
module dbus_decoder_test;
  localparam int CPB = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [31:0] addr_i = '0, wdata_i = '0;
  logic [3:0]  be_i = '0;
  logic [31:0] rdata_o;
  logic        ready_o, err_o, tx_o;

  int n_chk = 0, n_fail = 0;

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       tag;
  } exp_t;
  exp_t        sb_q[$];
  logic [7:0]  tx_exp_q[$];

  always #2 clk = ~clk;

  dbus_decoder #(.CLK_HZ(CPB * 10), .BAUD(10)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .be_i(be_i),
    .rdata_o(rdata_o), .ready_o(ready_o), .err_o(err_o), .tx_o(tx_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // bus monitor: compares every completion against the scoreboard
  always @(negedge clk) begin
    if (rst_ni && ready_o) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R2 unexpected ready", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(rdata_o == e.data, e.tag, rdata_o, e.data);
        check(err_o == e.err, {e.tag, " err"}, 32'(err_o), 32'(e.err));
      end
    end
  end

  // line monitor: decodes frames, samples mid-bit
  initial begin
    forever begin
      logic [7:0] got;
      @(negedge tx_o);
      if (rst_ni) begin
        repeat (CPB / 2) @(posedge clk);
        #1;
        check(tx_o == 1'b0, "R3 start bit", 32'(tx_o), 32'd0);
        for (int i = 0; i < 8; i++) begin
          repeat (CPB) @(posedge clk);
          #1;
          got[i] = tx_o;
        end
        repeat (CPB) @(posedge clk);
        #1;
        check(tx_o == 1'b1, "R3 stop bit", 32'(tx_o), 32'd1);
        if (tx_exp_q.size() == 0) check(1'b0, "R6 unexpected frame", 32'(got), 32'd0);
        else begin
          logic [7:0] e;
          e = tx_exp_q.pop_front();
          check(got == e, "R3 frame byte", 32'(got), 32'(e));
        end
      end
    end
  end

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] be, input logic [31:0] exp, input logic exp_err,
                        input bit fast, input string tag, output int lat);
    exp_t e;
    e.data = exp; e.err = exp_err; e.tag = tag;
    sb_q.push_back(e);
    if (we && a == 32'h0001_0000) tx_exp_q.push_back(d[7:0]);
    @(posedge clk); #1;
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = d; be_i = be;
    @(posedge clk); #1;
    // R7: disturb address and direction after acceptance
    req_i = 1'b0; we_i = ~we; addr_i = 32'h0000_0000; wdata_i = '1; be_i = '1;
    lat = 1;
    @(negedge clk);
    if (fast) check(ready_o == 1'b1, {tag, " R2 latency"}, 32'(ready_o), 32'd1);
    while (!ready_o) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #(4 * 150000);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    check(ready_o == 1'b0 && err_o == 1'b0, "R8 reset ready/err", {ready_o, err_o}, 32'd0);
    check(tx_o == 1'b1, "R8 reset line", 32'(tx_o), 32'd1);
    rst_ni = 1'b1;

    access(1, 32'h0000_0100, 32'h1122_3344, 4'hF, 32'h0, 0, 1, "R1 write full", lat);
    access(1, 32'h0000_0100, 32'hAABB_CCDD, 4'b0101, 32'h0, 0, 1, "R1 write lanes", lat);
    access(0, 32'h0000_0100, 32'h0, 4'h0, 32'h11BB_33DD, 0, 1, "R1 R7 read merged", lat);
    access(1, 32'h0000_1FFC, 32'hCAFE_F00D, 4'hF, 32'h0, 0, 1, "R1 write top", lat);
    access(1, 32'h0000_0000, 32'h0BAD_0000, 4'hF, 32'h0, 0, 1, "R1 write word0", lat);
    access(0, 32'h0000_1FFC, 32'h0, 4'h0, 32'hCAFE_F00D, 0, 1, "R1 read top", lat);
    access(1, 32'h0000_2000, 32'hDEAD_BEEF, 4'hF, 32'h0, 1, 1, "R6 write past ram", lat);
    access(1, 32'h0001_0004, 32'h0000_0077, 4'hF, 32'h0, 1, 1, "R6 write near tx", lat);
    access(0, 32'h8000_0000, 32'h0, 4'h0, 32'h0, 1, 1, "R6 read invalid", lat);
    access(0, 32'h0000_0000, 32'h0, 4'h0, 32'h0BAD_0000, 0, 1, "R6 word0 unchanged", lat);
    check(tx_o == 1'b1, "R6 line idle", 32'(tx_o), 32'd1);
    access(0, 32'h0001_0000, 32'h0, 4'h0, 32'h0, 0, 1, "R4 status idle", lat);

    access(1, 32'h0001_0000, 32'h0000_005A, 4'hF, 32'h0, 0, 0, "R3 write byte", lat);
    access(0, 32'h0001_0000, 32'h0, 4'h0, 32'h1, 0, 1, "R4 status busy", lat);
    access(1, 32'h0001_0000, 32'h0000_00C3, 4'hF, 32'h0, 0, 0, "R5 stalled write", lat);
    check(lat > 8 * CPB, "R5 stall length", 32'(lat), 32'(8 * CPB));
    access(0, 32'h0001_0000, 32'h0, 4'h0, 32'h1, 0, 1, "R5 second frame busy", lat);

    repeat (12 * CPB) @(posedge clk);
    access(0, 32'h0001_0000, 32'h0, 4'h0, 32'h0, 0, 1, "R4 status done", lat);
    repeat (4) @(posedge clk);
    check(sb_q.size() == 0, "R2 scoreboard drained", 32'(sb_q.size()), 32'd0);
    check(tx_exp_q.size() == 0, "R3 frames drained", 32'(tx_exp_q.size()), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule